// File: doc/BRIEF.md
# Cache Line Refill Beat Sequencer

After a cache miss, a 64-byte line is refilled from memory one double word (8 bytes) at a time, so a fill takes eight beats. This block accepts the miss address together with an order-policy bit. For every beat that memory delivers, it reports which double word of the line the beat carries. It also marks the beat that holds the requested word, so that word can be forwarded to the core before the rest of the line lands.

When the policy bit is 0, the fill starts with the critical double word and then wraps around the line. When it is 1, the fill runs strictly upward from the line base. The instruction cache and the data cache each hold their own policy bit, and either one drives `req_ascend_i`. The block captures the bit and the address when it accepts the miss, and keeps them for the whole fill. It pulses a completion flag once the line is full, and it accepts the next miss only after that pulse.

Top module: `refill_seq`

## Requirements
- R1: After reset the block is idle: `req_ready_o`=1, `line_done_o`=0, `beat_crit_o`=0.
- R2: With the policy bit at 1, the eight beats carry double-word indices 0,1,2,...,7 in that order, whatever the address.
- R3: With the policy bit at 0, the first beat carries index `req_addr_i[5:3]`, and each later beat carries the previous index plus 1 modulo 8. Address bits [2:0] and bits above 5 have no effect on the order.
- R4: `beat_crit_o` is 1 only while `beat_valid_i`=1 during a fill and the current index equals the captured `req_addr_i[5:3]`. This happens on exactly one beat per fill, under both policies.
- R5: The beat index advances only on a clock edge where `beat_valid_i`=1. While `beat_valid_i`=0, `beat_idx_o` holds its value and `beat_crit_o` stays 0.
- R6: `line_done_o` is 1 for exactly one cycle, the cycle after the edge that takes the eighth beat. `req_ready_o` is 0 in that cycle and returns to 1 in the cycle after.
- R7: A miss is accepted on an edge where `req_valid_i`=1 and `req_ready_o`=1. `req_ready_o` is 0 from the cycle after acceptance until the cycle after `line_done_o`, and any request seen in that span is ignored.
- R8: The address and policy bit are sampled at acceptance. Changes on `req_addr_i` or `req_ascend_i` during a fill do not alter the beat order.
- R9: `beat_valid_i` pulses while idle are ignored: they cause no `beat_crit_o`, no `line_done_o`, and no shift in the order of the next fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request present |
| req_addr_i | input | 32 | Miss byte address |
| req_ascend_i | input | 1 | Order policy: 0 critical first with wrap, 1 ascending from base |
| req_ready_o | output | 1 | Block can accept a miss |
| beat_valid_i | input | 1 | Memory delivers a beat this cycle |
| beat_idx_o | output | 3 | Double-word index of the current beat |
| beat_crit_o | output | 1 | Current valid beat holds the requested word |
| line_done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
A corrupted beat counter shows up on the next delivered beat: the index either repeats or skips, and the critical flag appears twice or not at all in that fill. A wrong start offset or a lost policy bit is visible on the very first beat of a fill. A counter that drifts while idle appears on the first beat of the following fill. A faulty end condition moves the completion pulse or the return of ready by at least one cycle relative to the eighth beat, and the bench checks both of these on exact cycles.

// File: rtl/refill_seq_pkg.sv
package refill_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/refill_beat_cnt.sv
module refill_beat_cnt #(
  parameter int unsigned BEATS = 8,
  localparam int unsigned CW = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(BEATS - 1));
endmodule

// File: rtl/refill_order.sv
module refill_order #(
  parameter int unsigned BEATS = 8,
  localparam int unsigned CW = $clog2(BEATS)
) (
  input  logic          ascend_i,
  input  logic [CW-1:0] crit_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] idx_o,
  output logic          is_crit_o
);
  logic [CW-1:0] start;

  // power-of-two beat count: truncating add gives the wrap
  assign start     = ascend_i ? '0 : crit_i;
  assign idx_o     = start + cnt_i;
  assign is_crit_o = (idx_o == crit_i);
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned BEAT_BYTES = 8,
  localparam int unsigned BEATS = LINE_BYTES / BEAT_BYTES,
  localparam int unsigned CW    = $clog2(BEATS),
  localparam int unsigned LSB   = $clog2(BEAT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_ascend_i,
  output logic              req_ready_o,
  input  logic              beat_valid_i,
  output logic [CW-1:0]     beat_idx_o,
  output logic              beat_crit_o,
  output logic              line_done_o
);
  fill_state_e   state_q, state_d;
  logic [CW-1:0] crit_q;
  logic          ascend_q;
  logic          accept, in_fill, take_beat;
  logic [CW-1:0] cnt;
  logic          cnt_last, is_crit;

  assign in_fill   = (state_q == ST_FILL);
  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign take_beat = in_fill && beat_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_FILL;
      ST_FILL: if (take_beat && cnt_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      crit_q   <= '0;
      ascend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        crit_q   <= req_addr_i[LSB +: CW];
        ascend_q <= req_ascend_i;
      end
    end
  end

  refill_beat_cnt #(.BEATS(BEATS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (take_beat),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  refill_order #(.BEATS(BEATS)) u_order (
    .ascend_i  (ascend_q),
    .crit_i    (crit_q),
    .cnt_i     (cnt),
    .idx_o     (beat_idx_o),
    .is_crit_o (is_crit)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign beat_crit_o = take_beat && is_crit;
  assign line_done_o = (state_q == ST_DONE);

  // checker state
  logic [BEATS-1:0] seen_q;
  logic [CW:0]      crit_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= '0;
      crit_cnt_q <= '0;
    end else if (accept) begin
      seen_q     <= '0;
      crit_cnt_q <= '0;
    end else if (take_beat) begin
      seen_q <= seen_q | (BEATS'(1) << beat_idx_o);
      if (beat_crit_o) crit_cnt_q <= crit_cnt_q + 1'b1;
    end
  end

  a_r3_all_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (&seen_q));
  a_r4_one_crit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (crit_cnt_q == 1));
  a_r2_base_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fill && ascend_q && cnt == '0) |-> (beat_idx_o == '0));
  a_r5_hold_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fill && !beat_valid_i) |=> $stable(beat_idx_o));
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> (!line_done_o && req_ready_o));
  a_r7_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> !req_ready_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !beat_crit_o);
endmodule

// File: tb/refill_seq_tb.sv
module refill_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ascend = 1'b0;
  logic        req_ready;
  logic        beat_valid = 1'b0;
  logic [2:0]  beat_idx;
  logic        beat_crit;
  logic        line_done;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .req_ascend_i (req_ascend),
    .req_ready_o  (req_ready),
    .beat_valid_i (beat_valid),
    .beat_idx_o   (beat_idx),
    .beat_crit_o  (beat_crit),
    .line_done_o  (line_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one full fill; gap inserts an idle cycle before each beat
  task automatic do_fill(input logic [31:0] addr, input logic asc, input bit gap);
    int crit = int'(addr[5:3]);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_ascend = asc;
    #1 chk("R7 ready before accept", int'(req_ready), 1);
    @(negedge clk);
    // disturb request inputs during the fill (R8, R7)
    req_valid = 1'b1; req_addr = ~addr; req_ascend = ~asc;
    #1 chk("R7 ready low in fill", int'(req_ready), 0);
    for (int k = 0; k < 8; k++) begin
      int e = asc ? k : ((crit + k) % 8);
      if (gap) begin
        beat_valid = 1'b0;
        #1;
        chk("R5 idx held on stall", int'(beat_idx), e);
        chk("R5 crit low on stall", int'(beat_crit), 0);
        @(negedge clk);
      end
      beat_valid = 1'b1;
      #1;
      if (asc) chk("R2 ascending idx", int'(beat_idx), e);
      else     chk("R3 wrap idx", int'(beat_idx), e);
      chk("R4 crit flag", int'(beat_crit), (e == crit) ? 1 : 0);
      chk("R6 no early done", int'(line_done), 0);
      @(negedge clk);
      beat_valid = 1'b0;
    end
    req_valid = 1'b0;
    #1;
    chk("R6 done pulse", int'(line_done), 1);
    chk("R6 ready low in done", int'(req_ready), 0);
    @(negedge clk);
    #1;
    chk("R6 done one cycle", int'(line_done), 0);
    chk("R6 ready back", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 done", int'(line_done), 0);
    chk("R1 crit", int'(beat_crit), 0);
  endtask

  task automatic t_idle_beats();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      beat_valid = 1'b1;
      #1;
      chk("R9 idle crit", int'(beat_crit), 0);
      chk("R9 idle done", int'(line_done), 0);
      chk("R9 idle ready", int'(req_ready), 1);
    end
    @(negedge clk);
    beat_valid = 1'b0;
    // next fill must still start at its own critical index
    do_fill(32'h0000_1028, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    do_fill(32'h0000_0000, 1'b1, 1'b0);   // R2 base address
    do_fill(32'hABCD_EF3F, 1'b1, 1'b0);   // R2 address ignored
    do_fill(32'h0000_0018, 1'b0, 1'b0);   // R3 crit 3
    do_fill(32'h8000_0038, 1'b0, 1'b1);   // R3 crit 7 wrap, R5 stalls
    do_fill(32'hFFFF_FFC7, 1'b0, 1'b0);   // R3 crit 0, low bits ignored
    do_fill(32'h0000_0025, 1'b1, 1'b1);   // R4 crit 4 ascending with stalls
    t_idle_beats();                       // R9
    finish_run();
  end
endmodule